// File: doc/BRIEF.md
# Partial-Access General Register File

This block holds eight 32-bit general registers for a CISC-style datapath. Each register can be reached at full width, and also through a 16-bit view of its low half. The first four registers also have two separate 8-bit views: their low byte and the byte just above it. A size code and a register index choose the view. The block has two combinational read ports that zero-extend narrow values, and one synchronous write port. That port merges a narrow value into the register and leaves the other bits unchanged.

Register 7 serves as the stack pointer. A stack-adjust port moves it down on a push and up on a pop, by 4 for a doubleword operand and by 2 for a word operand, so the stack grows toward lower addresses. The arithmetic is modular over the full 32-bit address range. Conflicting requests are reported on error outputs and have no effect on the registers.

Top module: `gpr_file`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, all eight registers are cleared to zero at that edge.
- R2: Size code 2'b10 (doubleword) reads and writes all 32 bits of register `idx`.
- R3: Size code 2'b01 (word) reads bits 15:0 of register `idx`, zero-extended to 32 bits. A word write replaces only bits 15:0 and keeps bits 31:16.
- R4: Size code 2'b00 (byte) with `idx` 0 to 3 addresses bits 7:0 of register `idx`. With `idx` 4 to 7 it addresses bits 15:8 of register `idx`-4. Byte reads are zero-extended, and a byte write takes `wr_data[7:0]` and changes only the addressed byte. In byte mode, registers 4 to 7 cannot be reached.
- R5: Size code 2'b11 is illegal. On a read port it drives the error output to 1 and the data to zero. On the write port with `wr_en` high it drives `wr_err` to 1 and no register changes.
- R6: Reads are combinational. A read of the register being written in the same cycle returns the old value, and the new value appears after the clock edge.
- R7: A push (`stk_push`=1, `stk_pop`=0) decrements register 7 by 4 when `stk_dword`=1 and by 2 when `stk_dword`=0, modulo 2^32.
- R8: A pop (`stk_pop`=1, `stk_push`=0) increments register 7 by the same step, modulo 2^32.
- R9: A push and a pop in the same cycle drive `stk_err` to 1 and leave register 7 unchanged.
- R10: A legal write to register 7 in the same cycle as a push or a pop takes priority. The stack step is discarded and `stk_err` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write request |
| wr_idx | input | 3 | Write register/view index |
| wr_size | input | 2 | Write size code |
| wr_data | input | 32 | Write data, narrow values taken from the low bits |
| wr_err | output | 1 | Write request with illegal size |
| rda_idx | input | 3 | Read port A index |
| rda_size | input | 2 | Read port A size code |
| rda_data | output | 32 | Read port A data, zero-extended |
| rda_err | output | 1 | Read port A illegal size |
| rdb_idx | input | 3 | Read port B index |
| rdb_size | input | 2 | Read port B size code |
| rdb_data | output | 32 | Read port B data, zero-extended |
| rdb_err | output | 1 | Read port B illegal size |
| stk_push | input | 1 | Stack pointer decrement request |
| stk_pop | input | 1 | Stack pointer increment request |
| stk_dword | input | 1 | Step size select: 1 gives 4 bytes, 0 gives 2 bytes |
| stk_err | output | 1 | Push/pop clash or clash with a stack pointer write |

## Verification
Directed sequences write distinct patterns at full width and then overwrite them through word and byte views. This separates a correct field merge from one that clobbers neighbouring bits, and it separates high-byte from low-byte addressing. Same-cycle read-of-write patterns separate a read-old design from a bypassing one. Stack sequences start near zero and near the top of the address range, so wrap-around, step size and push/pop direction show up in the value. A long random phase then mixes every size code, index and stack request, including illegal codes and the clash cases, against a behavioural model that is checked every cycle.

// File: rtl/gpr_pkg.sv
`timescale 1ns/1ps
// gpr_pkg: shared size codes and view kinds for the register file.
// Assumes the size code is carried on two bits at the block ports.
package gpr_pkg;
    localparam int GPR_COUNT = 8;
    localparam int GPR_XLEN  = 32;

    localparam logic [1:0] SZ_BYTE  = 2'b00;
    localparam logic [1:0] SZ_WORD  = 2'b01;
    localparam logic [1:0] SZ_DWORD = 2'b10;
    localparam logic [1:0] SZ_BAD   = 2'b11;

    typedef enum logic [1:0] {
        VW_FULL = 2'd0,
        VW_LO16 = 2'd1,
        VW_LO8  = 2'd2,
        VW_HI8  = 2'd3
    } gpr_view_e;
endpackage

// File: rtl/gpr_view_dec.sv
`timescale 1ns/1ps
// gpr_view_dec: turns a (size, index) pair into a physical register
// number, a bit-field view and a legality bit.
// Assumes BYTE_REGS is a power of two below NREG; in byte mode the
// index bit just above the byte-register field selects the high byte.
module gpr_view_dec
    import gpr_pkg::*;
#(
    parameter int NREG      = GPR_COUNT,
    parameter int BYTE_REGS = 4,
    localparam int IDX_W    = $clog2(NREG),
    localparam int BSEL_W   = $clog2(BYTE_REGS)
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [1:0]       size,
    output logic             legal,
    output logic [IDX_W-1:0] reg_sel,
    output gpr_view_e        view
);
    // decode the access request into register and view
    always_comb begin
        legal   = 1'b1;
        reg_sel = idx;
        view    = VW_FULL;
        case (size)
            SZ_DWORD: view = VW_FULL;
            SZ_WORD:  view = VW_LO16;
            SZ_BYTE: begin
                reg_sel = IDX_W'(idx[BSEL_W-1:0]);
                view    = idx[BSEL_W] ? VW_HI8 : VW_LO8;
            end
            default: begin
                legal   = 1'b0;
                reg_sel = '0;
            end
        endcase
    end
endmodule

// File: rtl/gpr_read_port.sv
`timescale 1ns/1ps
// gpr_read_port: one combinational read port. Selects a register view
// and zero-extends it to the full width; illegal requests read zero.
// Assumes XLEN is at least 16.
module gpr_read_port
    import gpr_pkg::*;
#(
    parameter int NREG      = GPR_COUNT,
    parameter int XLEN      = GPR_XLEN,
    parameter int BYTE_REGS = 4,
    localparam int IDX_W    = $clog2(NREG)
) (
    input  logic [NREG-1:0][XLEN-1:0] regs,
    input  logic [IDX_W-1:0]          idx,
    input  logic [1:0]                size,
    output logic [XLEN-1:0]           data,
    output logic                      err
);
    logic             legal;
    logic [IDX_W-1:0] reg_sel;
    gpr_view_e        view;
    logic [XLEN-1:0]  word;

    gpr_view_dec #(.NREG(NREG), .BYTE_REGS(BYTE_REGS)) i_dec (
        .idx     (idx),
        .size    (size),
        .legal   (legal),
        .reg_sel (reg_sel),
        .view    (view)
    );

    assign word = regs[reg_sel];
    assign err  = ~legal;

    // extract the selected field and zero-extend it
    always_comb begin
        data = '0;
        if (legal) begin
            case (view)
                VW_FULL: data = word;
                VW_LO16: data = XLEN'(word[15:0]);
                VW_LO8:  data = XLEN'(word[7:0]);
                VW_HI8:  data = XLEN'(word[15:8]);
                default: data = '0;
            endcase
        end
    end
endmodule

// File: rtl/gpr_stack_step.sv
`timescale 1ns/1ps
// gpr_stack_step: computes the next stack pointer for a push or a pop
// and flags clashing requests. Assumes the caller reports whether the
// write port targets the stack pointer in the same cycle.
module gpr_stack_step #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] sp,
    input  logic            push,
    input  logic            pop,
    input  logic            dword,
    input  logic            wr_hits_sp,
    output logic [XLEN-1:0] sp_next,
    output logic            step_en,
    output logic            err
);
    logic [XLEN-1:0] step;

    // step size in bytes from the operand size
    assign step = dword ? XLEN'(4) : XLEN'(2);

    // next pointer value and clash detection
    always_comb begin
        sp_next = push ? (sp - step) : (sp + step);
        step_en = (push ^ pop) & ~wr_hits_sp;
        err     = (push & pop) | ((push | pop) & wr_hits_sp);
    end
endmodule

// File: rtl/gpr_file.sv
`timescale 1ns/1ps
// gpr_file: eight general registers with full, word and byte views,
// two combinational read ports, one merging write port and a stack
// pointer adjust port. Synchronous active-low reset. The write port
// takes priority over a stack step on the stack pointer register.
module gpr_file
    import gpr_pkg::*;
#(
    parameter int NREG      = GPR_COUNT,
    parameter int XLEN      = GPR_XLEN,
    parameter int BYTE_REGS = 4,
    parameter int SP_IDX    = NREG - 1,
    localparam int IDX_W    = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [1:0]       wr_size,
    input  logic [XLEN-1:0]  wr_data,
    output logic             wr_err,
    input  logic [IDX_W-1:0] rda_idx,
    input  logic [1:0]       rda_size,
    output logic [XLEN-1:0]  rda_data,
    output logic             rda_err,
    input  logic [IDX_W-1:0] rdb_idx,
    input  logic [1:0]       rdb_size,
    output logic [XLEN-1:0]  rdb_data,
    output logic             rdb_err,
    input  logic             stk_push,
    input  logic             stk_pop,
    input  logic             stk_dword,
    output logic             stk_err
);
    logic [NREG-1:0][XLEN-1:0] regs_q;
    logic             wr_legal;
    logic [IDX_W-1:0] wr_reg;
    gpr_view_e        wr_view;
    logic             wr_fire;
    logic [XLEN-1:0]  wr_merged;
    logic             sp_wr_hit;
    logic [XLEN-1:0]  sp_next;
    logic             sp_step_en;

    gpr_view_dec #(.NREG(NREG), .BYTE_REGS(BYTE_REGS)) i_wdec (
        .idx     (wr_idx),
        .size    (wr_size),
        .legal   (wr_legal),
        .reg_sel (wr_reg),
        .view    (wr_view)
    );

    assign wr_fire   = wr_en & wr_legal;
    assign wr_err    = wr_en & ~wr_legal;
    assign sp_wr_hit = wr_fire & (wr_reg == IDX_W'(SP_IDX));

    // merge the write data into the old register contents
    always_comb begin
        wr_merged = regs_q[wr_reg];
        case (wr_view)
            VW_FULL: wr_merged        = wr_data;
            VW_LO16: wr_merged[15:0]  = wr_data[15:0];
            VW_LO8:  wr_merged[7:0]   = wr_data[7:0];
            VW_HI8:  wr_merged[15:8]  = wr_data[7:0];
            default: wr_merged        = regs_q[wr_reg];
        endcase
    end

    gpr_stack_step #(.XLEN(XLEN)) i_step (
        .sp         (regs_q[SP_IDX]),
        .push       (stk_push),
        .pop        (stk_pop),
        .dword      (stk_dword),
        .wr_hits_sp (sp_wr_hit),
        .sp_next    (sp_next),
        .step_en    (sp_step_en),
        .err        (stk_err)
    );

    // register storage, one update process per register
    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs_q[g] <= '0;
            end else if (wr_fire && wr_reg == IDX_W'(g)) begin
                regs_q[g] <= wr_merged;
            end else if (g == SP_IDX && sp_step_en) begin
                regs_q[g] <= sp_next;
            end
        end
    end

    gpr_read_port #(.NREG(NREG), .XLEN(XLEN), .BYTE_REGS(BYTE_REGS)) i_rda (
        .regs (regs_q),
        .idx  (rda_idx),
        .size (rda_size),
        .data (rda_data),
        .err  (rda_err)
    );

    gpr_read_port #(.NREG(NREG), .XLEN(XLEN), .BYTE_REGS(BYTE_REGS)) i_rdb (
        .regs (regs_q),
        .idx  (rdb_idx),
        .size (rdb_size),
        .data (rdb_data),
        .err  (rdb_err)
    );

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> regs_q == '0);

    // R5
    bad_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_size == SZ_BAD && !stk_push && !stk_pop)
        |=> regs_q == $past(regs_q));

    // R3
    word_upper_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_size == SZ_WORD)
        |=> regs_q[$past(wr_idx)][XLEN-1:16] == $past(regs_q[wr_idx][XLEN-1:16]));

    // R9
    push_pop_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stk_push && stk_pop && !sp_wr_hit)
        |=> regs_q[SP_IDX] == $past(regs_q[SP_IDX]));

    // R7
    push_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stk_push && !stk_pop && !sp_wr_hit)
        |=> regs_q[SP_IDX] == $past(regs_q[SP_IDX])
                              - ($past(stk_dword) ? XLEN'(4) : XLEN'(2)));

    // R8
    pop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stk_pop && !stk_push && !sp_wr_hit)
        |=> regs_q[SP_IDX] == $past(regs_q[SP_IDX])
                              + ($past(stk_dword) ? XLEN'(4) : XLEN'(2)));

    // R10
    sp_write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_size == SZ_DWORD && wr_idx == IDX_W'(SP_IDX))
        |=> regs_q[SP_IDX] == $past(wr_data));
endmodule

// File: tb/test_gpr_file.sv
`timescale 1ns/1ps
// test_gpr_file: behavioural reference model compared every clock.
module test_gpr_file;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [2:0]  wr_idx;
    logic [1:0]  wr_size;
    logic [31:0] wr_data;
    logic        wr_err;
    logic [2:0]  rda_idx, rdb_idx;
    logic [1:0]  rda_size, rdb_size;
    logic [31:0] rda_data, rdb_data;
    logic        rda_err, rdb_err;
    logic        stk_push, stk_pop, stk_dword, stk_err;

    int n_tests = 0;
    int n_fail  = 0;
    logic [31:0] m [8];

    always #5 clk = ~clk;

    gpr_file i_gpr_file (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_size(wr_size), .wr_data(wr_data), .wr_err(wr_err),
        .rda_idx(rda_idx), .rda_size(rda_size), .rda_data(rda_data), .rda_err(rda_err),
        .rdb_idx(rdb_idx), .rdb_size(rdb_size), .rdb_data(rdb_data), .rdb_err(rdb_err),
        .stk_push(stk_push), .stk_pop(stk_pop), .stk_dword(stk_dword), .stk_err(stk_err)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // expected read value from the model
    task automatic mread(input logic [2:0] idx, input logic [1:0] sz, output logic [31:0] d, output logic e);
        e = 1'b0;
        d = 32'h0;
        case (sz)
            2'b10: d = m[idx];
            2'b01: d = {16'h0, m[idx][15:0]};
            2'b00: d = (idx < 4) ? {24'h0, m[idx][7:0]} : {24'h0, m[idx - 4][15:8]};
            default: e = 1'b1;
        endcase
    endtask

    task automatic drive(input logic we, input logic [2:0] wi, input logic [1:0] ws, input logic [31:0] wd,
                         input logic [2:0] ai, input logic [1:0] as_, input logic [2:0] bi, input logic [1:0] bs,
                         input logic pu, input logic po, input logic dw);
        wr_en = we; wr_idx = wi; wr_size = ws; wr_data = wd;
        rda_idx = ai; rda_size = as_; rdb_idx = bi; rdb_size = bs;
        stk_push = pu; stk_pop = po; stk_dword = dw;
    endtask

    // compare one cycle, then advance model and design by one edge
    task automatic cyc(input string tag, input bit do_chk);
        logic [31:0] ea, eb, nsp;
        logic        ea_e, eb_e, sp_w, e_stk;
        logic [31:0] mn [8];
        int          step;
        #1;
        mread(rda_idx, rda_size, ea, ea_e);
        mread(rdb_idx, rdb_size, eb, eb_e);
        sp_w  = wr_en && (wr_size == 2'b10 || wr_size == 2'b01) && wr_idx == 3'd7;
        e_stk = (stk_push && stk_pop) || ((stk_push || stk_pop) && sp_w);
        if (do_chk) begin
            chk(tag, "rda_data", rda_data, ea);
            chk(tag, "rda_err", {31'h0, rda_err}, {31'h0, ea_e});
            chk(tag, "rdb_data", rdb_data, eb);
            chk(tag, "rdb_err", {31'h0, rdb_err}, {31'h0, eb_e});
            chk(tag, "wr_err", {31'h0, wr_err}, {31'h0, wr_en && wr_size == 2'b11});
            chk(tag, "stk_err", {31'h0, stk_err}, {31'h0, e_stk});
        end
        foreach (m[i]) mn[i] = m[i];
        step = stk_dword ? 4 : 2;
        if (stk_push && !stk_pop && !sp_w) begin
            nsp = m[7] - step;
            mn[7] = nsp;
        end
        if (stk_pop && !stk_push && !sp_w) begin
            nsp = m[7] + step;
            mn[7] = nsp;
        end
        if (wr_en) begin
            case (wr_size)
                2'b10: mn[wr_idx] = wr_data;
                2'b01: mn[wr_idx][15:0] = wr_data[15:0];
                2'b00: if (wr_idx < 4) mn[wr_idx][7:0] = wr_data[7:0];
                       else mn[wr_idx - 4][15:8] = wr_data[7:0];
                default: ;
            endcase
        end
        if (!rst_n) foreach (mn[i]) mn[i] = 32'h0;
        @(posedge clk);
        foreach (m[i]) m[i] = mn[i];
        @(negedge clk);
    endtask

    task automatic idle_read(input string tag, input logic [2:0] ai, input logic [1:0] as_,
                             input logic [2:0] bi, input logic [1:0] bs);
        drive(0, 0, 2'b10, 0, ai, as_, bi, bs, 0, 0, 0);
        cyc(tag, 1);
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        foreach (m[i]) m[i] = 32'h0;
        rst_n = 1'b0;
        drive(0, 0, 0, 0, 0, 2'b10, 0, 2'b10, 0, 0, 0);
        @(negedge clk);
        cyc("R1", 0);
        cyc("R1", 0);
        rst_n = 1'b1;
        // R1: every register reads zero after reset
        for (int i = 0; i < 8; i += 2) idle_read("R1", 3'(i), 2'b10, 3'(i + 1), 2'b10);

        // R2 / R6: full writes, same-cycle read sees old value
        for (int i = 0; i < 8; i++) begin
            drive(1, 3'(i), 2'b10, 32'hA5C3_0F10 + 32'(i) * 32'h1111_0101,
                  3'(i), 2'b10, 3'((i + 7) % 8), 2'b10, 0, 0, 0);
            cyc("R2 R6", 1);
        end
        for (int i = 0; i < 8; i += 2) idle_read("R2", 3'(i), 2'b10, 3'(i + 1), 2'b01);

        // R3: word writes keep the upper half
        for (int i = 0; i < 8; i++) begin
            drive(1, 3'(i), 2'b01, 32'hDEAD_0000 | 32'(i * 7 + 1), 3'(i), 2'b01, 3'(i), 2'b10, 0, 0, 0);
            cyc("R3", 1);
            idle_read("R3", 3'(i), 2'b10, 3'(i), 2'b01);
        end

        // R4: byte writes, low and high views
        for (int i = 0; i < 8; i++) begin
            drive(1, 3'(i), 2'b00, 32'hFFFF_FF00 | 32'(8'h3C + i), 3'(i), 2'b00, 3'(i % 4), 2'b10, 0, 0, 0);
            cyc("R4", 1);
            idle_read("R4", 3'(i % 4), 2'b10, 3'(i), 2'b00);
        end

        // R5: illegal size on reads and on writes
        drive(1, 3'd2, 2'b11, 32'h1234_5678, 3'd2, 2'b11, 3'd5, 2'b11, 0, 0, 0);
        cyc("R5", 1);
        for (int i = 0; i < 8; i += 2) idle_read("R5", 3'(i), 2'b10, 3'(i + 1), 2'b10);

        // R7: push wraps below zero
        drive(1, 3'd7, 2'b10, 32'h0000_0000, 3'd7, 2'b10, 3'd7, 2'b01, 0, 0, 0);
        cyc("R7", 1);
        drive(0, 0, 2'b10, 0, 3'd7, 2'b10, 3'd7, 2'b01, 1, 0, 0);
        cyc("R7", 1);
        drive(0, 0, 2'b10, 0, 3'd7, 2'b10, 3'd7, 2'b01, 1, 0, 1);
        cyc("R7", 1);
        idle_read("R7", 3'd7, 2'b10, 3'd7, 2'b01);

        // R8: pop wraps above the top
        drive(1, 3'd7, 2'b10, 32'hFFFF_FFFC, 3'd7, 2'b10, 3'd7, 2'b10, 0, 0, 0);
        cyc("R8", 1);
        drive(0, 0, 2'b10, 0, 3'd7, 2'b10, 3'd7, 2'b10, 0, 1, 1);
        cyc("R8", 1);
        drive(0, 0, 2'b10, 0, 3'd7, 2'b10, 3'd7, 2'b10, 0, 1, 0);
        cyc("R8", 1);
        idle_read("R8", 3'd7, 2'b10, 3'd7, 2'b01);

        // R9: push and pop together
        drive(0, 0, 2'b10, 0, 3'd7, 2'b10, 3'd6, 2'b10, 1, 1, 1);
        cyc("R9", 1);
        idle_read("R9", 3'd7, 2'b10, 3'd7, 2'b01);

        // R10: write to the stack pointer wins over a step
        drive(1, 3'd7, 2'b10, 32'h0000_1000, 3'd7, 2'b10, 3'd7, 2'b10, 1, 0, 1);
        cyc("R10", 1);
        drive(1, 3'd7, 2'b01, 32'h0000_2222, 3'd7, 2'b10, 3'd7, 2'b10, 0, 1, 0);
        cyc("R10", 1);
        idle_read("R10", 3'd7, 2'b10, 3'd7, 2'b01);

        // mixed random traffic
        for (int k = 0; k < 400; k++) begin
            drive(1'($urandom), 3'($urandom), 2'($urandom), $urandom,
                  3'($urandom), 2'($urandom), 3'($urandom), 2'($urandom),
                  1'($urandom), 1'($urandom), 1'($urandom));
            cyc("R2 R6 R9", 1);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule